// File: doc/BRIEF.md
# Training Approximation-Level Scheduler

The scheduler drives the mask count of a multiplier whose precision can be changed at run time: the number of low mantissa bits that the multiplier throws away. A training run begins at the deepest approximation, where the count is largest. The count then falls toward a final level as training proceeds. The final level is often zero, which means exact arithmetic, but any level can be chosen. Each iteration or epoch boundary arrives as a one-cycle tick. The scheduler counts these ticks and decides when the level drops.

There are three policies. Uniform keeps one level for a fixed number of ticks. Linear lowers the level by one every fixed number of ticks until the final level has been served. Adaptive reads a separate dwell count for every level from a table. Those counts are computed off-chip, normally in inverse proportion to the power drawn at each level, and together they add up to the length of the run. When the last dwell expires, a done flag goes high and the level output stays where it is.

Top module: `approx_sched`

## Requirements
- R1: After reset `lvl_o` is 0, `done_o` is 0, the scheduler is idle and every configuration register is 0.
- R2: Configuration writes with `cfg_we`. The address selects the target: an address below NLVL is the dwell count of that level; NLVL is the policy (0 uniform, 1 linear, 2 or 3 adaptive); NLVL+1 is the start level; NLVL+2 is the final level; NLVL+3 is the step length.
- R3: A `start_i` pulse loads the start level into `lvl_o` on the next clock, clears `done_o` and resets the tick count. This also restarts a run that is already in progress.
- R4: Uniform policy holds the start level for exactly step-length ticks and then raises `done_o`. The final level is ignored.
- R5: Linear policy holds each level for step-length ticks. It steps down by one from the start level to the final level. `done_o` rises on tick number (start-final+1)·step.
- R6: Adaptive policy holds level i for the number of ticks in its dwell entry, then moves to level i-1. It stops after the final level, so `done_o` rises after the sum of the dwell counts from the start level down to the final level.
- R7: A level whose dwell count is zero is passed without using a tick. The scheduler moves down one level per clock until it reaches a level with a nonzero dwell.
- R8: While a run is active, `lvl_o` changes only on the tick that completes a dwell, or on a zero-dwell skip. It never rises and never drops by more than one per clock.
- R9: Once `done_o` is high, ticks have no effect. `lvl_o` keeps the final level and `done_o` stays high until `start_i` or `clr_i`.
- R10: `clr_i` returns the scheduler to idle with `lvl_o` at 0 and `done_o` at 0 on the next clock. It takes priority over a `start_i` in the same cycle, and ticks while idle do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | CNT_W | Configuration write data |
| start_i | input | 1 | Begin a run at the start level |
| clr_i | input | 1 | Abort to idle, level 0 |
| tick_i | input | 1 | One iteration or epoch completed |
| lvl_o | output | LVL_W | Current mask count for the multiplier |
| done_o | output | 1 | Final level's dwell has expired |

## Verification
The hardest case to reach is a chain of zero-dwell levels inside an adaptive run. Levels are skipped on clock edges with no tick present, so the level can move between two ticks. The stimulus builds a dwell table with zeros between nonzero entries and waits a few idle clocks after each tick. The level is checked only after the skips have finished. The count of ticks before the done flag is also compared with the sum of the nonzero dwells. A second adaptive run moves the final level up, so the run has to end at a level other than zero.

// File: rtl/approx_sched.sv
module approx_sched #(
  parameter int LVL_W = 5,
  parameter int NLVL  = 24,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(NLVL + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             done_o
);
  localparam logic [AW-1:0] A_MODE = AW'(NLVL);
  localparam logic [AW-1:0] A_TOP  = AW'(NLVL + 1);
  localparam logic [AW-1:0] A_FIN  = AW'(NLVL + 2);
  localparam logic [AW-1:0] A_STEP = AW'(NLVL + 3);

  logic [CNT_W-1:0] dwell_q [NLVL];
  logic [1:0]       mode_q;
  logic [LVL_W-1:0] top_q, fin_q, lvl_q;
  logic [CNT_W-1:0] step_q, cnt_q, dwell_cur;
  logic             run_q, done_q, last, expire;

  for (genvar g = 0; g < NLVL; g++) begin : g_dwell
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dwell_q[g] <= '0;
      else if (cfg_we && cfg_addr == AW'(g)) dwell_q[g] <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0; top_q <= '0; fin_q <= '0; step_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_MODE) mode_q <= cfg_wdata[1:0];
      if (cfg_addr == A_TOP)  top_q  <= cfg_wdata[LVL_W-1:0];
      if (cfg_addr == A_FIN)  fin_q  <= cfg_wdata[LVL_W-1:0];
      if (cfg_addr == A_STEP) step_q <= cfg_wdata;
    end

  always_comb begin
    dwell_cur = step_q;
    if (mode_q[1]) begin
      dwell_cur = '0;
      for (int i = 0; i < NLVL; i++)
        if (lvl_q == LVL_W'(i)) dwell_cur = dwell_q[i];
    end
  end

  assign last   = (mode_q == 2'd0) || (lvl_q <= fin_q) || (lvl_q == '0);
  assign expire = run_q && ((dwell_cur == '0) ||
                  (tick_i && ({1'b0, cnt_q} + 1'b1) == {1'b0, dwell_cur}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; lvl_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0; done_q <= 1'b0; lvl_q <= '0; cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1; done_q <= 1'b0; lvl_q <= top_q; cnt_q <= '0;
    end else if (expire) begin
      cnt_q <= '0;
      if (last) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        lvl_q <= lvl_q - 1'b1;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end

  assign lvl_o  = lvl_q;
  assign done_o = done_q;
endmodule

// File: rtl/approx_sched_chk.sv
module approx_sched_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             clr_i,
  input logic             tick_i,
  input logic [LVL_W-1:0] lvl_o,
  input logic             done_o
);
  p_never_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !clr_i) |=> (lvl_o <= $past(lvl_o)));

  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !clr_i) |=> (lvl_o == $past(lvl_o) || lvl_o == $past(lvl_o) - 1'b1));

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !clr_i) |=> (done_o && $stable(lvl_o)));

  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (lvl_o == '0 && !done_o));

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i) |=> !done_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && lvl_o == '0 && !start_i && tick_i && $past(clr_i)) |=> (lvl_o == '0 && !done_o));
endmodule

bind approx_sched approx_sched_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i),
  .tick_i(tick_i), .lvl_o(lvl_o), .done_o(done_o)
);

// File: tb/sim_approx_sched.sv
module sim_approx_sched;
  localparam int LVL_W = 5, NLVL = 24, CNT_W = 16;
  localparam int AW = $clog2(NLVL + 4);
  localparam int A_MODE = NLVL, A_TOP = NLVL + 1, A_FIN = NLVL + 2, A_STEP = NLVL + 3;

  // vector: mode[19:18] top[17:13] fin[12:8] step[7:0]
  localparam logic [19:0] VEC [4] = '{
    {2'd0, 5'd7, 5'd2, 8'd5},
    {2'd1, 5'd6, 5'd0, 8'd3},
    {2'd1, 5'd5, 5'd2, 8'd2},
    {2'd1, 5'd3, 5'd1, 8'd1}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0, start_i = 0, clr_i = 0, tick_i = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic [LVL_W-1:0] lvl_o;
  logic done_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  approx_sched #(.LVL_W(LVL_W), .NLVL(NLVL), .CNT_W(CNT_W)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = CNT_W'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1; @(negedge clk); tick_i = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lvl", int'(lvl_o), 0); chk("R1 done", int'(done_o), 0);
    rst_n = 1;
    tick();
    chk("R10 idle tick lvl", int'(lvl_o), 0); chk("R10 idle tick done", int'(done_o), 0);

    for (int v = 0; v < 4; v++) begin
      automatic int md = int'(VEC[v][19:18]);
      automatic int tp = int'(VEC[v][17:13]);
      automatic int fn = int'(VEC[v][12:8]);
      automatic int st = int'(VEC[v][7:0]);
      automatic int tot = (md == 0) ? st : (tp - fn + 1) * st;
      cfg(A_MODE, md); cfg(A_TOP, tp); cfg(A_FIN, fn); cfg(A_STEP, st);
      pulse_start();
      chk("R3 start level", int'(lvl_o), tp); chk("R3 start done", int'(done_o), 0);
      for (int n = 1; n <= tot + 1; n++) begin
        automatic int el, ed;
        tick();
        if (md == 0) el = tp;
        else el = (n / st <= tp - fn) ? tp - n / st : fn;
        ed = (n >= tot) ? 1 : 0;
        if (md == 0) begin
          chk("R4 uniform lvl", int'(lvl_o), el); chk("R4 uniform done", int'(done_o), ed);
        end else begin
          chk("R5 linear lvl", int'(lvl_o), el); chk("R5 linear done", int'(done_o), ed);
        end
      end
      chk("R9 held after done", int'(lvl_o), (md == 0) ? tp : fn);
    end

    // adaptive: dwell[4]=2 [3]=0 [2]=3 [1]=0 [0]=1
    cfg(4, 2); cfg(3, 0); cfg(2, 3); cfg(1, 0); cfg(0, 1);
    cfg(A_MODE, 2); cfg(A_TOP, 4); cfg(A_FIN, 0);
    pulse_start();
    chk("R6 adaptive start", int'(lvl_o), 4);
    tick(); chk("R6 dwell 4 held", int'(lvl_o), 4);
    tick(); chk("R7 zero dwell skipped", int'(lvl_o), 2);
    tick(); tick(); chk("R6 dwell 2 held", int'(lvl_o), 2); chk("R6 not done", int'(done_o), 0);
    tick(); chk("R7 skip to 0", int'(lvl_o), 0); chk("R6 still running", int'(done_o), 0);
    tick(); chk("R6 done after sum", int'(done_o), 1); chk("R6 final lvl", int'(lvl_o), 0);
    tick(); chk("R9 tick ignored done", int'(done_o), 1); chk("R9 tick ignored lvl", int'(lvl_o), 0);

    // adaptive with nonzero final level
    cfg(A_FIN, 2);
    pulse_start();
    repeat (4) tick();
    chk("R6 final 2 running", int'(done_o), 0); chk("R6 final 2 lvl", int'(lvl_o), 2);
    tick();
    chk("R6 final 2 done", int'(done_o), 1); chk("R6 final 2 held", int'(lvl_o), 2);

    // config encoding: step length address changes linear dwell
    cfg(A_MODE, 1); cfg(A_TOP, 2); cfg(A_FIN, 1); cfg(A_STEP, 2);
    pulse_start();
    tick(); chk("R2 step 2 held", int'(lvl_o), 2);
    tick(); chk("R2 step 2 moved", int'(lvl_o), 1);
    chk("R8 no move without tick", int'(lvl_o), 1);

    // restart mid-run
    pulse_start(); chk("R3 restart", int'(lvl_o), 2);

    // clear wins over start
    @(negedge clk); clr_i = 1; start_i = 1; @(negedge clk); clr_i = 0; start_i = 0;
    chk("R10 clear lvl", int'(lvl_o), 0); chk("R10 clear done", int'(done_o), 0);
    tick(); chk("R10 idle after clear", int'(lvl_o), 0); chk("R10 idle done", int'(done_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule